// File: doc/BRIEF.md
# Dual-Bank Register File with Pair Access and Predicate Lookup

This block is the general-purpose register storage for a two-sided datapath. Side A and side B each own a bank of thirty-two 32-bit registers. Each bank has four read ports and two single-register write ports. On every read port a select bit picks either the local bank or that side's cross path. The cross path carries one register from the opposite bank, and every unit on the side that selects it gets the same value in the same cycle.

Wider operands live in even/odd register pairs. A pair port on each bank writes and reads 64-bit values. It also handles 40-bit values: the odd register holds bits 39:32 in its low byte and zero above them. A 3-bit predicate selector with an invert bit is decoded against the six condition registers (registers 0 to 2 of each bank). The block returns whether the qualified instruction should execute. A constant per-register flag marks registers 4 to 7 of each bank as usable for circular addressing.

Top module: `dual_bank_regfile`

## Requirements
- R1: After a synchronous active-low reset every register of both banks reads zero and both pair error strobes are low.
- R2: A single-register write takes effect at the clock edge. Read ports are combinational, so a read of a register written in the same cycle returns the old value.
- R3: When several writes in one cycle hit the same register, write port 1 beats write port 0, and both single-register ports beat the pair port.
- R4: A 64-bit pair write with an even base stores data[31:0] in the even register and data[63:32] in the odd register. A 64-bit pair read (long bit 0) returns {odd, even} for the pair containing the given index; address bit 0 is ignored.
- R5: A 40-bit pair write (long bit 1) stores data[31:0] in the even register and {24'b0, data[39:32]} in the odd register. A 40-bit pair read returns {24'b0, odd[7:0], even}.
- R6: A pair write with an odd base index changes neither register. The bank's error strobe is high for exactly the cycle after the request.
- R7: A read port whose cross-select bit is 1 returns register xp_addr of the opposite bank. All cross-selecting ports on a side get that same value, while the other ports still read their own addresses locally.
- R8: Predicate selector encoding: 0 means unconditional (true), 1 to 3 test A0 to A2, 4 to 6 test B0 to B2, and 7 is reserved (false). A tested register is true when it is non-zero.
- R9: The invert bit flips the result for selector values 1 to 6 and has no effect on selectors 0 and 7.
- R10: Circular-addressing flag bit i of each bank is 1 exactly for i in 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_rd_addr | input | 20 | Side A read addresses, 5 bits per port |
| a_rd_xsel | input | 4 | Side A per-port cross-path select |
| a_rd_data | output | 128 | Side A read data, 32 bits per port |
| b_rd_addr | input | 20 | Side B read addresses |
| b_rd_xsel | input | 4 | Side B per-port cross-path select |
| b_rd_data | output | 128 | Side B read data |
| a_xp_addr | input | 5 | Bank B register sent over side A's cross path |
| b_xp_addr | input | 5 | Bank A register sent over side B's cross path |
| a_wr_en | input | 2 | Bank A single write enables |
| a_wr_addr | input | 10 | Bank A write addresses |
| a_wr_data | input | 64 | Bank A write data, 32 bits per port |
| b_wr_en | input | 2 | Bank B single write enables |
| b_wr_addr | input | 10 | Bank B write addresses |
| b_wr_data | input | 64 | Bank B write data |
| a_pw_en | input | 1 | Bank A pair write enable |
| a_pw_long | input | 1 | Bank A pair write is 40-bit |
| a_pw_addr | input | 5 | Bank A pair write base index |
| a_pw_data | input | 64 | Bank A pair write data |
| a_pw_err | output | 1 | Bank A odd-base rejection strobe |
| b_pw_en | input | 1 | Bank B pair write enable |
| b_pw_long | input | 1 | Bank B pair write is 40-bit |
| b_pw_addr | input | 5 | Bank B pair write base index |
| b_pw_data | input | 64 | Bank B pair write data |
| b_pw_err | output | 1 | Bank B odd-base rejection strobe |
| a_pr_addr | input | 5 | Bank A pair read index |
| a_pr_long | input | 1 | Bank A pair read is 40-bit |
| a_pr_data | output | 64 | Bank A pair read data |
| b_pr_addr | input | 5 | Bank B pair read index |
| b_pr_long | input | 1 | Bank B pair read is 40-bit |
| b_pr_data | output | 64 | Bank B pair read data |
| pred_sel | input | 3 | Predicate selector |
| pred_inv | input | 1 | Predicate sense invert |
| pred_true | output | 1 | Qualified instruction executes |
| a_circ | output | 32 | Bank A circular-eligible flags |
| b_circ | output | 32 | Bank B circular-eligible flags |

## Verification
The storage assertions assume fully known inputs after reset. The pair checks (even-half storage, zero fill and odd-base rejection) apply only in cycles with no single-register write to the same bank. The bench keeps single and pair writes in separate cycles everywhere except the one priority test, which only the port-priority assertion covers. Predicate and cross-path assertions look at combinational outputs under any input, so the bench sweeps every selector, invert value and cross address freely.

// File: rtl/regfile_pkg.sv
// Shared types and helpers for the dual-bank register file.
// Assumes: nothing beyond IEEE 1800-2017.
package regfile_pkg;

    // Predicate selector codes (R8)
    typedef enum logic [2:0] {
        PS_ALWAYS = 3'd0,
        PS_A0     = 3'd1,
        PS_A1     = 3'd2,
        PS_A2     = 3'd3,
        PS_B0     = 3'd4,
        PS_B1     = 3'd5,
        PS_B2     = 3'd6,
        PS_NEVER  = 3'd7
    } pred_sel_e;

    // Registers 4..7 of a bank may serve circular addressing (R10)
    function automatic logic circ_eligible(int idx);
        return (idx >= 4) && (idx <= 7);
    endfunction

endpackage

// File: rtl/rf_bank.sv
// One register bank: storage, single and pair write merge, local reads,
// cross-path source read, pair read with 40-bit zero fill, odd-base
// rejection strobe, condition register taps and circular flags.
// Assumes: NREG is a power of two, DW < LONG_W < 2*DW, NREG >= 8.
module rf_bank
    import regfile_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int DW     = 32,
    parameter int NRD    = 4,
    parameter int NWR    = 2,
    parameter int LONG_W = 40,
    localparam int AW    = $clog2(NREG),
    localparam int XW    = LONG_W - DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NRD*AW-1:0]   rd_addr,
    output logic [NRD*DW-1:0]   rd_data,
    input  logic [AW-1:0]       xp_addr,
    output logic [DW-1:0]       xp_data,
    input  logic [AW-1:0]       pr_addr,
    input  logic                pr_long,
    output logic [2*DW-1:0]     pr_data,
    input  logic [NWR-1:0]      wr_en,
    input  logic [NWR*AW-1:0]   wr_addr,
    input  logic [NWR*DW-1:0]   wr_data,
    input  logic                pw_en,
    input  logic                pw_long,
    input  logic [AW-1:0]       pw_addr,
    input  logic [2*DW-1:0]     pw_data,
    output logic                pw_err,
    output logic [3*DW-1:0]     cond_val,
    output logic [NREG-1:0]     circ_flag
);

    logic [DW-1:0] mem [NREG];
    logic [DW-1:0] nxt [NREG];
    logic          pw_ok;
    logic [AW-1:0] pw_even;
    logic [AW-1:0] pw_odd;
    logic [AW-1:0] pr_even;
    logic [AW-1:0] pr_odd;
    logic [DW-1:0] pr_lo;
    logic [DW-1:0] pr_hi;

    assign pw_ok   = pw_en && !pw_addr[0];
    assign pw_even = {pw_addr[AW-1:1], 1'b0};
    assign pw_odd  = {pw_addr[AW-1:1], 1'b1};

    // Next-state merge: pair write first, then single ports in rising priority
    always_comb begin
        nxt = mem;
        for (int i = 0; i < NREG; i++) begin
            if (pw_ok && (pw_even == AW'(i)))
                nxt[i] = pw_data[DW-1:0];
            if (pw_ok && (pw_odd == AW'(i)))
                nxt[i] = pw_long ? {{(DW-XW){1'b0}}, pw_data[DW+XW-1:DW]}
                                 : pw_data[2*DW-1:DW];
            for (int k = 0; k < NWR; k++) begin
                if (wr_en[k] && (wr_addr[k*AW +: AW] == AW'(i)))
                    nxt[i] = wr_data[k*DW +: DW];
            end
        end
    end

    // Register storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) mem <= '{default: '0};
        else        mem <= nxt;
    end

    // Odd-base rejection strobe, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) pw_err <= 1'b0;
        else        pw_err <= pw_en && pw_addr[0];
    end

    // Local read ports
    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rd_data[r*DW +: DW] = mem[rd_addr[r*AW +: AW]];
        end
    endgenerate

    // Cross-path source read for the opposite side
    assign xp_data = mem[xp_addr];

    // Pair read with optional 40-bit zero fill
    assign pr_even = {pr_addr[AW-1:1], 1'b0};
    assign pr_odd  = {pr_addr[AW-1:1], 1'b1};
    assign pr_lo   = mem[pr_even];
    assign pr_hi   = mem[pr_odd];
    assign pr_data = pr_long ? {{(2*DW-LONG_W){1'b0}}, pr_hi[XW-1:0], pr_lo}
                             : {pr_hi, pr_lo};

    // Condition register taps (registers 0..2)
    assign cond_val = {mem[2], mem[1], mem[0]};

    // Constant circular-eligibility flags
    generate
        for (genvar c = 0; c < NREG; c++) begin : g_circ
            assign circ_flag[c] = circ_eligible(c);
        end
    endgenerate

    // R6: odd base raises the strobe next cycle
    p_odd_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && pw_addr[0]) |=> pw_err);

    // R6: strobe only follows a rejected request
    p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pw_err |-> $past(pw_en && pw_addr[0]));

    // R6: rejected pair leaves its base register untouched
    p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && pw_addr[0] && (wr_en == '0))
        |=> (mem[$past(pw_addr)] == $past(mem[pw_addr])));

    // R4: accepted pair stores its low half in the even register
    p_pair_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_ok && (wr_en == '0))
        |=> (mem[$past(pw_even)] == $past(pw_data[DW-1:0])));

    // R5: 40-bit pair leaves the odd register zero above bit XW-1
    p_long_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_ok && pw_long && (wr_en == '0))
        |=> (mem[$past(pw_odd)][DW-1:XW] == '0));

    // R3: highest-numbered write port always lands
    p_top_port_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[NWR-1]
        |=> (mem[$past(wr_addr[(NWR-1)*AW +: AW])] == $past(wr_data[(NWR-1)*DW +: DW])));

endmodule

// File: rtl/rf_xbar.sv
// Per-side operand select: each read port takes either its local bank
// value or the single cross-path value broadcast from the other bank.
// Assumes: clk and rst_n serve only the embedded assertions.
module rf_xbar #(
    parameter int NRD = 4,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRD*DW-1:0] local_data,
    input  logic [DW-1:0]     cross_data,
    input  logic [NRD-1:0]    cross_sel,
    output logic [NRD*DW-1:0] unit_data
);

    // One select mux per unit port
    generate
        for (genvar u = 0; u < NRD; u++) begin : g_sel
            assign unit_data[u*DW +: DW] = cross_sel[u] ? cross_data
                                                        : local_data[u*DW +: DW];
        end
        // R7: any two cross-selecting ports see identical operands
        for (genvar u = 1; u < NRD; u++) begin : g_chk
            p_bcast_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cross_sel[0] && cross_sel[u])
                |-> (unit_data[0 +: DW] == unit_data[u*DW +: DW]));
        end
    endgenerate

endmodule

// File: rtl/rf_pred.sv
// Predicate lookup: decodes the selector against six condition
// registers and applies the invert bit.
// Assumes: condition values arrive as {reg2, reg1, reg0} per bank.
module rf_pred
    import regfile_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3*DW-1:0] cond_a,
    input  logic [3*DW-1:0] cond_b,
    input  logic [2:0]      pred_sel,
    input  logic            pred_inv,
    output logic            pred_true
);

    pred_sel_e sel;
    assign sel = pred_sel_e'(pred_sel);

    // Selector decode with non-zero test and sense inversion
    always_comb begin
        unique case (sel)
            PS_ALWAYS: pred_true = 1'b1;
            PS_A0:     pred_true = (|cond_a[0*DW +: DW]) ^ pred_inv;
            PS_A1:     pred_true = (|cond_a[1*DW +: DW]) ^ pred_inv;
            PS_A2:     pred_true = (|cond_a[2*DW +: DW]) ^ pred_inv;
            PS_B0:     pred_true = (|cond_b[0*DW +: DW]) ^ pred_inv;
            PS_B1:     pred_true = (|cond_b[1*DW +: DW]) ^ pred_inv;
            PS_B2:     pred_true = (|cond_b[2*DW +: DW]) ^ pred_inv;
            default:   pred_true = 1'b0;
        endcase
    end

    // R8: unconditional selector always executes
    p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sel == 3'd0) |-> pred_true);

    // R8: reserved selector never executes
    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_sel == 3'd7) |-> !pred_true);

endmodule

// File: rtl/dual_bank_regfile.sv
// Top: two register banks, their cross-path operand selects and the
// shared predicate lookup.
// Assumes: xp addresses index the opposite bank; side A receives bank B.
module dual_bank_regfile #(
    parameter int NREG   = 32,
    parameter int DW     = 32,
    parameter int NRD    = 4,
    parameter int NWR    = 2,
    parameter int LONG_W = 40,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRD*AW-1:0] a_rd_addr,
    input  logic [NRD-1:0]    a_rd_xsel,
    output logic [NRD*DW-1:0] a_rd_data,
    input  logic [NRD*AW-1:0] b_rd_addr,
    input  logic [NRD-1:0]    b_rd_xsel,
    output logic [NRD*DW-1:0] b_rd_data,
    input  logic [AW-1:0]     a_xp_addr,
    input  logic [AW-1:0]     b_xp_addr,
    input  logic [NWR-1:0]    a_wr_en,
    input  logic [NWR*AW-1:0] a_wr_addr,
    input  logic [NWR*DW-1:0] a_wr_data,
    input  logic [NWR-1:0]    b_wr_en,
    input  logic [NWR*AW-1:0] b_wr_addr,
    input  logic [NWR*DW-1:0] b_wr_data,
    input  logic              a_pw_en,
    input  logic              a_pw_long,
    input  logic [AW-1:0]     a_pw_addr,
    input  logic [2*DW-1:0]   a_pw_data,
    output logic              a_pw_err,
    input  logic              b_pw_en,
    input  logic              b_pw_long,
    input  logic [AW-1:0]     b_pw_addr,
    input  logic [2*DW-1:0]   b_pw_data,
    output logic              b_pw_err,
    input  logic [AW-1:0]     a_pr_addr,
    input  logic              a_pr_long,
    output logic [2*DW-1:0]   a_pr_data,
    input  logic [AW-1:0]     b_pr_addr,
    input  logic              b_pr_long,
    output logic [2*DW-1:0]   b_pr_data,
    input  logic [2:0]        pred_sel,
    input  logic              pred_inv,
    output logic              pred_true,
    output logic [NREG-1:0]   a_circ,
    output logic [NREG-1:0]   b_circ
);

    logic [NRD*DW-1:0] a_local;
    logic [NRD*DW-1:0] b_local;
    logic [DW-1:0]     a_to_b;
    logic [DW-1:0]     b_to_a;
    logic [3*DW-1:0]   a_cond;
    logic [3*DW-1:0]   b_cond;

    rf_bank #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR), .LONG_W(LONG_W)) u_bank_a (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(a_rd_addr), .rd_data(a_local),
        .xp_addr(b_xp_addr), .xp_data(a_to_b),
        .pr_addr(a_pr_addr), .pr_long(a_pr_long), .pr_data(a_pr_data),
        .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data),
        .pw_en(a_pw_en), .pw_long(a_pw_long), .pw_addr(a_pw_addr),
        .pw_data(a_pw_data), .pw_err(a_pw_err),
        .cond_val(a_cond), .circ_flag(a_circ)
    );

    rf_bank #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR), .LONG_W(LONG_W)) u_bank_b (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(b_rd_addr), .rd_data(b_local),
        .xp_addr(a_xp_addr), .xp_data(b_to_a),
        .pr_addr(b_pr_addr), .pr_long(b_pr_long), .pr_data(b_pr_data),
        .wr_en(b_wr_en), .wr_addr(b_wr_addr), .wr_data(b_wr_data),
        .pw_en(b_pw_en), .pw_long(b_pw_long), .pw_addr(b_pw_addr),
        .pw_data(b_pw_data), .pw_err(b_pw_err),
        .cond_val(b_cond), .circ_flag(b_circ)
    );

    rf_xbar #(.NRD(NRD), .DW(DW)) u_xbar_a (
        .clk(clk), .rst_n(rst_n),
        .local_data(a_local), .cross_data(b_to_a),
        .cross_sel(a_rd_xsel), .unit_data(a_rd_data)
    );

    rf_xbar #(.NRD(NRD), .DW(DW)) u_xbar_b (
        .clk(clk), .rst_n(rst_n),
        .local_data(b_local), .cross_data(a_to_b),
        .cross_sel(b_rd_xsel), .unit_data(b_rd_data)
    );

    rf_pred #(.DW(DW)) u_pred (
        .clk(clk), .rst_n(rst_n),
        .cond_a(a_cond), .cond_b(b_cond),
        .pred_sel(pred_sel), .pred_inv(pred_inv),
        .pred_true(pred_true)
    );

endmodule

// File: tb/dual_bank_regfile_tb.sv
// Self-checking bench: sweeps registers, pairs, cross paths and predicates.
module dual_bank_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int DW   = 32;
    localparam int NRD  = 4;
    localparam int NWR  = 2;
    localparam int AW   = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic [NRD*AW-1:0] a_rd_addr, b_rd_addr;
    logic [NRD-1:0]    a_rd_xsel, b_rd_xsel;
    logic [NRD*DW-1:0] a_rd_data, b_rd_data;
    logic [AW-1:0]     a_xp_addr, b_xp_addr;
    logic [NWR-1:0]    a_wr_en, b_wr_en;
    logic [NWR*AW-1:0] a_wr_addr, b_wr_addr;
    logic [NWR*DW-1:0] a_wr_data, b_wr_data;
    logic              a_pw_en, a_pw_long, b_pw_en, b_pw_long;
    logic [AW-1:0]     a_pw_addr, b_pw_addr, a_pr_addr, b_pr_addr;
    logic [2*DW-1:0]   a_pw_data, b_pw_data, a_pr_data, b_pr_data;
    logic              a_pw_err, b_pw_err, a_pr_long, b_pr_long;
    logic [2:0]        pred_sel;
    logic              pred_inv, pred_true;
    logic [NREG-1:0]   a_circ, b_circ;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ma [NREG];
    logic [DW-1:0] mb [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_rd_addr(a_rd_addr), .a_rd_xsel(a_rd_xsel), .a_rd_data(a_rd_data),
        .b_rd_addr(b_rd_addr), .b_rd_xsel(b_rd_xsel), .b_rd_data(b_rd_data),
        .a_xp_addr(a_xp_addr), .b_xp_addr(b_xp_addr),
        .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
        .a_pw_en(a_pw_en), .a_pw_long(a_pw_long), .a_pw_addr(a_pw_addr),
        .a_pw_data(a_pw_data), .a_pw_err(a_pw_err),
        .b_pw_en(b_pw_en), .b_pw_long(b_pw_long), .b_pw_addr(b_pw_addr),
        .b_pw_data(b_pw_data), .b_pw_err(b_pw_err),
        .a_pr_addr(a_pr_addr), .a_pr_long(a_pr_long), .a_pr_data(a_pr_data),
        .b_pr_addr(b_pr_addr), .b_pr_long(b_pr_long), .b_pr_data(b_pr_data),
        .pred_sel(pred_sel), .pred_inv(pred_inv), .pred_true(pred_true),
        .a_circ(a_circ), .b_circ(b_circ)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_wr_en = '0; b_wr_en = '0; a_pw_en = 1'b0; b_pw_en = 1'b0;
        a_pw_long = 1'b0; b_pw_long = 1'b0;
    endtask

    // Set all four read ports of both sides to addr+p, locally
    task automatic set_reads(int base);
        a_rd_xsel = '0; b_rd_xsel = '0;
        for (int p = 0; p < NRD; p++) begin
            a_rd_addr[p*AW +: AW] = AW'((base + p) % NREG);
            b_rd_addr[p*AW +: AW] = AW'((base + p) % NREG);
        end
    endtask

    task automatic sweep_reads(string req);
        for (int i = 0; i < NREG; i++) begin
            set_reads(i);
            #1;
            for (int p = 0; p < NRD; p++) begin
                chk(req, {32'h0, a_rd_data[p*DW +: DW]}, {32'h0, ma[(i+p)%NREG]});
                chk(req, {32'h0, b_rd_data[p*DW +: DW]}, {32'h0, mb[(i+p)%NREG]});
            end
        end
    endtask

    function automatic logic exp_pred(int s, logic inv);
        logic v;
        case (s)
            0: return 1'b1;
            7: return 1'b0;
            1, 2, 3: v = |ma[s-1];
            default: v = |mb[s-4];
        endcase
        return v ^ inv;
    endfunction

    task automatic pred_sweep(string tag);
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 2; v++) begin
                pred_sel = 3'(s); pred_inv = v[0];
                #1;
                chk((s == 0 || s == 7 || v == 0) ? {"R8 ", tag} : {"R9 ", tag},
                    {63'h0, pred_true}, {63'h0, exp_pred(s, v[0])});
            end
        end
    endtask

    // Single-register write on one bank via both ports
    task automatic wr2(logic bank_b, int r0, logic [31:0] d0, int r1, logic [31:0] d1);
        @(negedge clk);
        idle();
        if (!bank_b) begin
            a_wr_en = 2'b11;
            a_wr_addr = {AW'(r1), AW'(r0)}; a_wr_data = {d1, d0};
        end else begin
            b_wr_en = 2'b11;
            b_wr_addr = {AW'(r1), AW'(r0)}; b_wr_data = {d1, d0};
        end
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        a_wr_addr = '0; b_wr_addr = '0; a_wr_data = '0; b_wr_data = '0;
        a_pw_addr = '0; b_pw_addr = '0; a_pw_data = '0; b_pw_data = '0;
        a_pr_addr = '0; b_pr_addr = '0; a_pr_long = 1'b0; b_pr_long = 1'b0;
        a_xp_addr = '0; b_xp_addr = '0; pred_sel = '0; pred_inv = 1'b0;
        set_reads(0);
        for (int i = 0; i < NREG; i++) begin ma[i] = '0; mb[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared state
        sweep_reads("R1 reset");
        chk("R1 err strobes", {62'h0, a_pw_err, b_pw_err}, 64'h0);

        // R10: circular flags
        for (int i = 0; i < NREG; i++) begin
            chk("R10 flag a", {63'h0, a_circ[i]}, {63'h0, (i >= 4 && i <= 7)});
            chk("R10 flag b", {63'h0, b_circ[i]}, {63'h0, (i >= 4 && i <= 7)});
        end

        // R2: fill both banks, checking read-before-write on each write cycle
        for (int i = 0; i < NREG; i += 2) begin
            logic [31:0] d0, d1, e0, e1;
            d0 = 32'hA5000000 ^ (i * 32'h01030507);
            d1 = 32'h3C000000 ^ ((i+1) * 32'h01030507);
            e0 = ~d0; e1 = ~d1;
            wr2(1'b0, i, d0, i+1, d1);
            b_wr_en = 2'b11; b_wr_addr = {AW'(i+1), AW'(i)}; b_wr_data = {e1, e0};
            set_reads(i);
            #1;
            chk("R2 old value a", {32'h0, a_rd_data[31:0]}, {32'h0, ma[i]});
            chk("R2 old value b", {32'h0, b_rd_data[63:32]}, {32'h0, mb[i+1]});
            ma[i] = d0; ma[i+1] = d1; mb[i] = e0; mb[i+1] = e1;
        end
        @(negedge clk);
        idle();
        sweep_reads("R2 readback");

        // R3: same-register collision: port1 beats port0, singles beat pair
        @(negedge clk);
        idle();
        a_wr_en = 2'b11; a_wr_addr = {AW'(9), AW'(9)};
        a_wr_data = {32'h11112222, 32'h33334444};
        a_pw_en = 1'b1; a_pw_addr = AW'(8); a_pw_data = 64'h55556666_77778888;
        @(negedge clk);
        idle();
        ma[9] = 32'h11112222; ma[8] = 32'h77778888;
        set_reads(8);
        #1;
        chk("R3 port1 wins", {32'h0, a_rd_data[63:32]}, {32'h0, ma[9]});
        chk("R3 pair low kept", {32'h0, a_rd_data[31:0]}, {32'h0, ma[8]});

        // R4: 64-bit pair write/read on every pair of bank B
        for (int q = 0; q < NREG; q += 2) begin
            logic [63:0] pd;
            pd = {32'hF00D0000 + 32'(q), 32'h0BAD0000 + 32'(q * 7)};
            @(negedge clk);
            idle();
            b_pw_en = 1'b1; b_pw_addr = AW'(q); b_pw_data = pd;
            mb[q] = pd[31:0]; mb[q+1] = pd[63:32];
        end
        @(negedge clk);
        idle();
        for (int q = 0; q < NREG; q++) begin
            b_pr_addr = AW'(q); b_pr_long = 1'b0;
            #1;
            chk("R4 pair read", b_pr_data, {mb[q|1], mb[q & ~1]});
        end
        sweep_reads("R4 halves");

        // R5: 40-bit pair write and 40-bit pair read
        @(negedge clk);
        idle();
        a_pw_en = 1'b1; a_pw_long = 1'b1; a_pw_addr = AW'(12);
        a_pw_data = 64'hFFFFFF5A_12345678;
        @(negedge clk);
        idle();
        ma[12] = 32'h12345678; ma[13] = 32'h0000005A;
        set_reads(12);
        #1;
        chk("R5 odd zero fill", {32'h0, a_rd_data[63:32]}, 64'h5A);
        chk("R5 even low", {32'h0, a_rd_data[31:0]}, 64'h12345678);
        a_pr_addr = AW'(12); a_pr_long = 1'b1;
        #1;
        chk("R5 long read", a_pr_data, 64'h0000005A_12345678);
        b_pr_addr = AW'(6); b_pr_long = 1'b1;
        #1;
        chk("R5 long read masks", b_pr_data, {24'h0, mb[7][7:0], mb[6]});

        // R6: odd base rejected, strobe for one cycle only
        @(negedge clk);
        idle();
        a_pw_en = 1'b1; a_pw_addr = AW'(13); a_pw_data = 64'hDEADBEEF_CAFEF00D;
        #1;
        chk("R6 no strobe yet", {63'h0, a_pw_err}, 64'h0);
        @(negedge clk);
        idle();
        chk("R6 strobe high", {63'h0, a_pw_err}, 64'h1);
        chk("R6 other bank quiet", {63'h0, b_pw_err}, 64'h0);
        set_reads(12);
        #1;
        chk("R6 reg12 kept", {32'h0, a_rd_data[31:0]}, {32'h0, ma[12]});
        chk("R6 reg13 kept", {32'h0, a_rd_data[63:32]}, {32'h0, ma[13]});
        a_rd_addr[2*AW +: AW] = AW'(14);
        #1;
        chk("R6 reg14 kept", {32'h0, a_rd_data[95:64]}, {32'h0, ma[14]});
        @(negedge clk);
        chk("R6 strobe drops", {63'h0, a_pw_err}, 64'h0);

        // R7: cross-path broadcast with every select pattern
        for (int x = 0; x < NREG; x++) begin
            for (int m = 0; m < 16; m++) begin
                set_reads(x + 3);
                a_xp_addr = AW'(x); b_xp_addr = AW'(NREG - 1 - x);
                a_rd_xsel = 4'(m); b_rd_xsel = 4'(m);
                #1;
                for (int p = 0; p < NRD; p++) begin
                    chk("R7 side a", {32'h0, a_rd_data[p*DW +: DW]},
                        {32'h0, m[p] ? mb[x] : ma[(x+3+p)%NREG]});
                    chk("R7 side b", {32'h0, b_rd_data[p*DW +: DW]},
                        {32'h0, m[p] ? ma[NREG-1-x] : mb[(x+3+p)%NREG]});
                end
            end
        end

        // R8/R9: two condition patterns so each selector sees zero and non-zero
        wr2(1'b0, 0, 32'h0, 1, 32'h5);
        ma[0] = 32'h0; ma[1] = 32'h5;
        @(negedge clk); idle();
        wr2(1'b0, 2, 32'h0, 2, 32'h0);
        ma[2] = 32'h0;
        @(negedge clk); idle();
        wr2(1'b1, 0, 32'h1, 1, 32'h0);
        mb[0] = 32'h1; mb[1] = 32'h0;
        @(negedge clk); idle();
        wr2(1'b1, 2, 32'h80000000, 2, 32'h80000000);
        mb[2] = 32'h80000000;
        @(negedge clk); idle();
        pred_sweep("set1");
        wr2(1'b0, 0, 32'h7, 1, 32'h0);
        ma[0] = 32'h7; ma[1] = 32'h0;
        @(negedge clk); idle();
        wr2(1'b0, 2, 32'h3, 2, 32'h3);
        ma[2] = 32'h3;
        @(negedge clk); idle();
        wr2(1'b1, 0, 32'h0, 1, 32'h2);
        mb[0] = 32'h0; mb[1] = 32'h2;
        @(negedge clk); idle();
        wr2(1'b1, 2, 32'h0, 2, 32'h0);
        mb[2] = 32'h0;
        @(negedge clk); idle();
        pred_sweep("set2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule